// File: doc/BRIEF.md
# Clock-Generator Configuration I2C Slave

This block is the serial configuration port of a clock generator. It holds a bank of six configuration bytes that the clock-control logic reads as plain levels. A host programs the bank and reads it back over a two-wire I2C bus. The block samples SCL and SDA with a faster system clock, passes both through a synchronizer, and finds start and stop conditions, bit edges and byte boundaries in the sampled lines. SDA is open-drain, so the block drives it only through a pull-low enable.

There is no register addressing. A write sends the device address, then a command byte and a count byte, then data. The block acknowledges the command and count bytes and throws their values away. Data fills the bank from byte 0 upwards. A read returns a count byte and then the bank in ascending order. The configuration output is a set of static levels, not a stream, so it carries no valid/ready handshake. The bus itself is the only flow control: the host sets the pace on SCL, and the slave can refuse a byte only by withholding its acknowledge.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, the bank holds byte0=0x1F, byte1=0xFF, byte2=0xFF, byte3=0x00, byte4=0x00 and byte5=0x06, and SDA is released (sda_oe=0).
- R2: Only the 7-bit address 0x69 is acknowledged (0xD2 to write, 0xD3 to read). After any other address the slave leaves SDA released, acknowledging nothing, until the next start, and the bank does not change.
- R3: In a write, the two bytes that follow the address (command and count) are acknowledged and discarded. Each later byte is acknowledged and lands in byte 0, 1, 2, and so on in that order, with bits sent MSB first. The bank changes only while SCL is low.
- R4: A stop after any complete byte keeps every byte received so far and leaves the remaining bytes unchanged.
- R5: Every start, repeated starts included, restarts the address phase and sets the data pointer back to byte 0.
- R6: Data bytes after byte 5 are acknowledged and have no effect on the bank.
- R7: A read returns the count byte 0x06 first, then bytes 0 through 5 in order, MSB first.
- R8: Bits 7..4 of byte 0 are a read-only identification field with the value 0001. No write changes them.
- R9: Bit 0 of byte 0 always reads back as 0. The latch behind it (cfg_o bit 0) still holds the value last written.
- R10: When the master does not acknowledge a read byte, the slave stops sending and keeps SDA released until the next start.
- R11: The slave starts driving SDA low only while SCL is low, so it never creates a start or stop condition itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; loads the bank defaults |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases the line |
| cfg_o | output | 48 | Bank latches; byte k is bits 8k+7..8k |

## Verification
Two situations are the hardest to reach from the pins. The first is a repeated start in the middle of a write. The bench reaches it by raising SDA while SCL is low right after an acknowledge, then producing a fresh start, and checks that the next data byte lands in byte 0 and not in the byte the pointer had reached. The second is ID protection together with the hidden bit-0 latch. For this the bench sweeps all sixteen low-nibble values of byte 0, puts the complement in the high nibble of each write, and compares both the latch output and the value read back against values it computes. A sweep of all 128 addresses checks that the slave stays silent for every address except its own.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } i2c_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int                      NUM_BYTES = 6,
  parameter int                      PW        = 4,
  parameter logic [8*NUM_BYTES-1:0]  RST_VAL   = '0,
  parameter logic [7:0]              ID_MASK   = 8'hF0,
  parameter logic [7:0]              RDZ_MASK  = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PW-1:0]            wr_idx,
  input  logic [7:0]               wr_data,
  input  logic [PW-1:0]            rd_idx,
  output logic [7:0]               rd_data,
  output logic [8*NUM_BYTES-1:0]   cfg_o
);
  logic [7:0] bank_q [NUM_BYTES];
  logic [7:0] bank_d [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    // only byte 0 carries protected identification bits
    localparam logic [7:0] KEEP = (g == 0) ? ID_MASK : 8'h00;
    assign bank_d[g] = (wr_en && wr_idx == PW'(g))
                     ? ((bank_q[g] & KEEP) | (wr_data & ~KEEP))
                     : bank_q[g];
    assign cfg_o[8*g +: 8] = bank_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BYTES; i++) bank_q[i] <= RST_VAL[8*i +: 8];
    end else begin
      for (int i = 0; i < NUM_BYTES; i++) bank_q[i] <= bank_d[i];
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (rd_idx == PW'(i)) rd_data = (i == 0) ? (bank_q[i] & ~RDZ_MASK) : bank_q[i];
    end
  end
endmodule

// File: rtl/i2c_block_fsm.sv
module i2c_block_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_BYTES = 6,
  parameter int         PW        = 4,
  parameter logic [7:0] CNT_BYTE  = 8'h06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [PW-1:0] rd_idx,
  output logic          sel
);
  localparam logic [PW-1:0] HDR      = PW'(2);
  localparam logic [PW-1:0] PTR_LAST = PW'(NUM_BYTES + 2);

  i2c_state_t    state_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          done_q, rw_q, mack_q;
  logic [PW-1:0] ptr_q, ptr_inc;
  logic [7:0]    tx_byte;

  assign ptr_inc = (ptr_q == PTR_LAST) ? ptr_q : ptr_q + PW'(1);
  assign tx_byte = (ptr_q == '0) ? CNT_BYTE : rd_data;
  assign rd_idx  = ptr_q - PW'(1);
  assign wr_idx  = ptr_q - HDR;
  assign wr_data = sh_q;
  assign wr_en   = (state_q == ST_WR_BYTE) && scl_fall && done_q &&
                   (ptr_q >= HDR) && (ptr_q < PTR_LAST);
  assign sel     = (state_q != ST_IDLE) && (state_q != ST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sda_oe  <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      sda_oe  <= 1'b0;
      bit_q   <= '0;
      done_q  <= 1'b0;
      ptr_q   <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise) begin
            sh_q   <= {sh_q[6:0], sda_s};
            bit_q  <= bit_q + 3'd1;
            done_q <= (bit_q == 3'd7);
          end else if (scl_fall && done_q) begin
            done_q <= 1'b0;
            bit_q  <= '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                state_q <= ST_ADDR_ACK;
                sda_oe  <= 1'b1;
                rw_q    <= sh_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              state_q <= ST_WR_ACK;
              sda_oe  <= 1'b1;
              ptr_q   <= ptr_inc;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_q <= '0;
            if (rw_q) begin
              state_q <= ST_RD_BYTE;
              sh_q    <= tx_byte;
              sda_oe  <= ~tx_byte[7];
              ptr_q   <= ptr_inc;
            end else begin
              state_q <= ST_WR_BYTE;
              sda_oe  <= 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_q <= ST_WR_BYTE;
            sda_oe  <= 1'b0;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              state_q <= ST_RD_ACK;
              sda_oe  <= 1'b0;
              bit_q   <= '0;
              mack_q  <= 1'b0;
            end else begin
              sh_q   <= {sh_q[6:0], 1'b1};
              sda_oe <= ~sh_q[6];
              bit_q  <= bit_q + 3'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_RD_BYTE;
              sh_q    <= tx_byte;
              sda_oe  <= ~tx_byte[7];
              ptr_q   <= ptr_inc;
            end else begin
              state_q <= ST_IDLE;
              sda_oe  <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int                     NUM_BYTES   = 6,
  parameter logic [6:0]             DEV_ADDR    = 7'h69,
  parameter int                     SYNC_STAGES = 2,
  parameter logic [8*NUM_BYTES-1:0] RST_VAL     = 48'h06_00_00_FF_FF_1F,
  parameter logic [7:0]             ID_MASK     = 8'hF0,
  parameter logic [7:0]             RDZ_MASK    = 8'h01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [8*NUM_BYTES-1:0] cfg_o
);
  localparam int         PW       = $clog2(NUM_BYTES + 3);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_BYTES);

  logic scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, addressed;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_block_fsm #(
    .DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES), .PW(PW), .CNT_BYTE(CNT_BYTE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_sync), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .sel(addressed)
  );

  cfg_regbank #(
    .NUM_BYTES(NUM_BYTES), .PW(PW), .RST_VAL(RST_VAL),
    .ID_MASK(ID_MASK), .RDZ_MASK(RDZ_MASK)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/clkcfg_i2c_checker.sv
module clkcfg_i2c_checker #(
  parameter int NUM_BYTES = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_sync,
  input logic                   sda_oe,
  input logic                   addressed,
  input logic [8*NUM_BYTES-1:0] cfg_o
);
  // R11
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync);

  // R2
  oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> addressed);

  // R8
  id_bits_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_o[7:4]));

  // R3
  cfg_update_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> !scl_sync);
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .sda_oe(sda_oe),
  .addressed(addressed), .cfg_o(cfg_o)
);

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic [47:0] cfg_o;
  wire  sda_line = sda_drv & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] exp_b [6];
  logic [7:0] wbuf [16];

  always #2.5 clk = ~clk;

  clkcfg_i2c_slave u_clkcfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_drv = 1; scl_drv = 1; hq(); sda_drv = 0; hq(); scl_drv = 0; hq(); endtask
  task automatic bus_rstart(); sda_drv = 1; hq(); scl_drv = 1; hq(); sda_drv = 0; hq(); scl_drv = 0; hq(); endtask
  task automatic bus_stop(); sda_drv = 0; hq(); scl_drv = 1; hq(); sda_drv = 1; hq(); endtask
  task automatic send_bit(input logic b); sda_drv = b; hq(); scl_drv = 1; hq(); hq(); scl_drv = 0; hq(); endtask
  task automatic recv_bit(output logic b); sda_drv = 1; hq(); scl_drv = 1; hq(); b = sda_line; hq(); scl_drv = 0; hq(); endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  function automatic void model_write(input int n);
    for (int k = 0; k < n && k < 6; k++)
      exp_b[k] = (k == 0) ? {exp_b[0][7:4], wbuf[0][3:0]} : wbuf[k];
  endfunction

  task automatic check_bank(input string req);
    for (int k = 0; k < 6; k++)
      chk(cfg_o[8*k +: 8] == exp_b[k], req, cfg_o[8*k +: 8], exp_b[k]);
  endtask

  // full header then n data bytes from wbuf
  task automatic do_write(input int n, input string req);
    bit ack;
    bus_start();
    wr_byte(8'hD2, ack); chk(ack, "R2 address ack", ack, 1);
    wr_byte(8'h3B, ack); chk(ack, "R3 command ack", ack, 1);
    wr_byte(8'hC4, ack); chk(ack, "R3 count ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      wr_byte(wbuf[k], ack);
      chk(ack, req, ack, 1);
    end
    bus_stop();
    model_write(n);
  endtask

  // count byte plus n data bytes, last byte not acknowledged
  task automatic do_read(input int n, input string req);
    bit ack;
    logic [7:0] d, e;
    bus_start();
    wr_byte(8'hD3, ack); chk(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k <= n; k++) begin
      rd_byte(k < n, d);
      e = (k == 0) ? 8'h06 : ((k == 1) ? (exp_b[0] & 8'hFE) : exp_b[k-1]);
      chk(d == e, req, d, e);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    exp_b[0] = 8'h1F; exp_b[1] = 8'hFF; exp_b[2] = 8'hFF;
    exp_b[3] = 8'h00; exp_b[4] = 8'h00; exp_b[5] = 8'h06;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_bank("R1 default");
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);

    // R7 / R9 read of defaults
    do_read(6, "R7 default read-back");

    // R3 / R8 / R9 full write
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hC3;
    wbuf[3] = 8'h5A; wbuf[4] = 8'h81; wbuf[5] = 8'h7E;
    do_write(6, "R3 data ack");
    check_bank("R3 full write");
    chk(cfg_o[0] == 1'b1, "R9 latch holds bit0", cfg_o[0], 1);
    do_read(6, "R7 read after write");

    // R4 stop after two data bytes
    wbuf[0] = 8'h02; wbuf[1] = 8'h11;
    do_write(2, "R4 data ack");
    check_bank("R4 partial write");

    // R6 bytes beyond byte 5
    for (int k = 0; k < 9; k++) wbuf[k] = 8'(8'h20 + 8'(k * 17));
    do_write(9, "R6 extra byte ack");
    check_bank("R6 extra bytes ignored");

    // R5 repeated start resets pointer
    bus_start();
    wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    wr_byte(8'h09, ack); wr_byte(8'h44, ack);
    bus_rstart();
    wr_byte(8'hD2, ack); chk(ack, "R5 address after repeated start", ack, 1);
    wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    wr_byte(8'h0C, ack);
    bus_stop();
    exp_b[0] = {exp_b[0][7:4], 4'hC}; exp_b[1] = 8'h44;
    check_bank("R5 pointer restart");

    // R10 master NACK ends read
    bus_start();
    wr_byte(8'hD3, ack);
    rd_byte(1'b1, d); chk(d == 8'h06, "R10 count", d, 8'h06);
    rd_byte(1'b0, d); chk(d == (exp_b[0] & 8'hFE), "R10 byte0", d, exp_b[0] & 8'hFE);
    rd_byte(1'b0, d); chk(d == 8'hFF, "R10 released after nack", d, 8'hFF);
    bus_stop();

    // R2 sweep of all addresses (write direction)
    for (int a = 0; a < 128; a++) begin
      bus_start();
      wr_byte({7'(a), 1'b0}, ack);
      chk(ack == (a == 'h69), "R2 address decode", ack, a == 'h69);
      wr_byte(8'h00, ack);
      chk(ack == (a == 'h69), "R2 silent until start", ack, a == 'h69);
      bus_stop();
    end
    check_bank("R2 bank untouched by sweep");

    // R8 / R9 sweep of byte 0 values
    for (int v = 0; v < 16; v++) begin
      wbuf[0] = {4'(15 - v), 4'(v)};
      do_write(1, "R8 byte0 ack");
      chk(cfg_o[7:0] == {4'h1, 4'(v)}, "R8 id bits kept", cfg_o[7:0], {4'h1, 4'(v)});
      do_read(1, "R9 byte0 read-back");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule